// File: doc/BRIEF.md
# Shift-Add Constant Multiplier by 1717

This block multiplies a signed two's-complement sample by the fixed constant 1717. It contains no general multiplier. The product comes from four adders or subtractors that are joined by hardwired shifts. Each adder forms an odd intermediate multiple of the input from two earlier multiples. The multiples 3x and 11x are built first and shared. Two graph variants then finish the product, and a parameter picks one:

- Variant 0: 693x = 64·11x − 11x, then 1717x = 1024x + 693x.
- Variant 1: 1013x = 1024x − 11x, then 1717x = 64·11x + 1013x.

Each node is sign-extended to the input width plus ceil(log2) of its own multiple. No node can overflow, and the result keeps full precision. A second parameter makes the block produce −1717·x. In that mode every adder that would subtract its unshifted operand is rewritten. It subtracts the shifted operand instead, so no adder needs a half-adder tail at its low end. The stage that follows must absorb the sign.

The sample enters and leaves on valid/ready streams. With the output register enabled, an accepted sample appears one cycle later. A held result stays stable until the consumer takes it. The input is ready whenever the register is empty or is being drained in the same cycle. With the register disabled, the path is purely combinational and ready passes straight back from output to input.

Top module: `shiftadd_cmul`

## Requirements
- R1: With NEGATE=0, out_data is exactly 1717·in_data as a two's-complement value of W_IN+11 bits.
- R2: With NEGATE=1, out_data is exactly −1717·in_data, with the same width.
- R3: GRAPH=0 (tail 693x then 1717x) and GRAPH=1 (tail 1013x then 1717x) give the same product for every input, in both sign modes.
- R4: The result is exact at the input extremes without overflow. For W_IN=16, in_data=−32768 gives −56262656 (NEGATE=0) or +56262656 (NEGATE=1), and in_data=32767 gives +56260939 or −56260939.
- R5: out_data bit 0 equals in_data bit 0, because every node value is an odd multiple of the input.
- R6: With REG_OUT=1, a sample accepted at a clock edge (in_valid and in_ready both high) is presented with out_valid high right after that edge.
- R7: With REG_OUT=1, while out_valid is high and out_ready is low, out_valid and out_data hold, and in_ready is low. in_ready equals (not out_valid) or out_ready.
- R8: While rst_n is low and after its release with no input, out_valid is low.
- R9: With REG_OUT=0, out_valid equals in_valid, in_ready equals out_ready, and out_data follows in_data within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | W_IN | Signed input sample |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | W_IN+11 | Signed product, ±1717·in_data |

## Verification
Zero, ±1 and small values show whether the low-order partial terms line up. These are the terms where a wrong shift count or a lost sign extension first shows. The two input extremes exercise the top bit of every node and tell a correctly sized tail apart from one a bit short. A long pseudo-random stream runs through all four combinations of graph variant and sign mode. It is checked against a plain multiply, both with the consumer always ready and with random back-pressure. The back-pressure run tells apart a register that holds its result from one that drops or overwrites it.

// File: rtl/cmul_pkg.sv
`timescale 1ns/1ps
package cmul_pkg;
  localparam int CMUL_COEF = 1717;

  // Width that holds k*x for any signed x of width w, k > 1 odd
  function automatic int node_width(input int w, input int k);
    return w + $clog2(k);
  endfunction

  function automatic int out_width(input int w);
    return node_width(w, CMUL_COEF);
  endfunction
endpackage

// File: rtl/cmul_node.sv
`timescale 1ns/1ps
// One adder node: y = (+/-)(a <<< SHIFT) + (+/-)b, both edges never negative together
module cmul_node #(
  parameter int WA     = 16,
  parameter int WB     = 16,
  parameter int WO     = 18,
  parameter int SHIFT  = 1,
  parameter bit NEG_A  = 1'b0,
  parameter bit NEG_B  = 1'b0
) (
  input  logic signed [WA-1:0] a,
  input  logic signed [WB-1:0] b,
  output logic signed [WO-1:0] y
);
  logic signed [WO-1:0] a_ext, b_ext, a_sh, term_a, term_b;

  assign a_ext  = {{(WO-WA){a[WA-1]}}, a};
  assign b_ext  = {{(WO-WB){b[WB-1]}}, b};
  assign a_sh   = a_ext <<< SHIFT;
  assign term_a = NEG_A ? -a_sh  : a_sh;
  assign term_b = NEG_B ? -b_ext : b_ext;
  assign y      = term_a + term_b;

  // a_r5_node_parity (R5): shifted edge is even, so parity comes from b
  always_comb begin
    if (!$isunknown(b))
      a_r5_node_parity: assert (y[0] == b[0]);
  end
endmodule

// File: rtl/cmul_graph.sv
`timescale 1ns/1ps
module cmul_graph
  import cmul_pkg::*;
#(
  parameter int W_IN   = 16,
  parameter int GRAPH  = 0,
  parameter bit NEGATE = 1'b0,
  localparam int W3    = node_width(W_IN, 3),
  localparam int W11   = node_width(W_IN, 11),
  localparam int WMID  = node_width(W_IN, (GRAPH == 0) ? 693 : 1013),
  localparam int WOUT  = out_width(W_IN)
) (
  input  logic signed [W_IN-1:0] x,
  output logic signed [WOUT-1:0] prod
);
  logic signed [W3-1:0]   m3;
  logic signed [W11-1:0]  m11;
  logic signed [WMID-1:0] mmid;

  // shared multiples: 3x = 2x + x, 11x = 8x + 3x
  cmul_node #(.WA(W_IN), .WB(W_IN), .WO(W3), .SHIFT(1), .NEG_A(1'b0), .NEG_B(1'b0))
    u_m3 (.a(x), .b(x), .y(m3));
  cmul_node #(.WA(W_IN), .WB(W3), .WO(W11), .SHIFT(3), .NEG_A(1'b0), .NEG_B(1'b0))
    u_m11 (.a(x), .b(m3), .y(m11));

  generate
    if (GRAPH == 0) begin : g_tail_693
      // +: 693x = 64*11x - 11x ; -: -693x = 11x - 64*11x
      cmul_node #(.WA(W11), .WB(W11), .WO(WMID), .SHIFT(6),
                  .NEG_A(NEGATE), .NEG_B(!NEGATE))
        u_mid (.a(m11), .b(m11), .y(mmid));
      // +: 1024x + 693x ; -: -1024x + (-693x)
      cmul_node #(.WA(W_IN), .WB(WMID), .WO(WOUT), .SHIFT(10),
                  .NEG_A(NEGATE), .NEG_B(1'b0))
        u_out (.a(x), .b(mmid), .y(prod));
    end else begin : g_tail_1013
      // +: 1013x = 1024x - 11x ; -: -1013x = 11x - 1024x
      cmul_node #(.WA(W_IN), .WB(W11), .WO(WMID), .SHIFT(10),
                  .NEG_A(NEGATE), .NEG_B(!NEGATE))
        u_mid (.a(x), .b(m11), .y(mmid));
      // +: 64*11x + 1013x ; -: -64*11x + (-1013x)
      cmul_node #(.WA(W11), .WB(WMID), .WO(WOUT), .SHIFT(6),
                  .NEG_A(NEGATE), .NEG_B(1'b0))
        u_out (.a(m11), .b(mmid), .y(prod));
    end
  endgenerate

  // a_r2_sign (R1, R2): product sign follows input sign and mode
  always_comb begin
    if (!$isunknown(x) && x != '0)
      a_r2_sign: assert (prod[WOUT-1] == (x[W_IN-1] ^ NEGATE));
  end
endmodule

// File: rtl/cmul_ostage.sv
`timescale 1ns/1ps
module cmul_ostage #(
  parameter int W       = 27,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end

      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/shiftadd_cmul.sv
`timescale 1ns/1ps
module shiftadd_cmul
  import cmul_pkg::*;
#(
  parameter int W_IN    = 16,
  parameter int GRAPH   = 0,
  parameter bit NEGATE  = 1'b0,
  parameter bit REG_OUT = 1'b1,
  localparam int WOUT   = out_width(W_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W_IN-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WOUT-1:0] out_data
);
  logic signed [WOUT-1:0] prod;

  cmul_graph #(.W_IN(W_IN), .GRAPH(GRAPH), .NEGATE(NEGATE)) u_graph (
    .x    (in_data),
    .prod (prod)
  );

  cmul_ostage #(.W(WOUT), .REG_OUT(REG_OUT)) u_ostage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (prod),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: tb/shiftadd_cmul_bench.sv
`timescale 1ns/1ps
module shiftadd_cmul_bench;
  localparam int W  = 16;
  localparam int WO = W + 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_ready = 1'b1;
  logic bp_en = 1'b0;

  logic rdy_a, rdy_b, rdy_c, rdy_d;
  logic vld_a, vld_b, vld_c, vld_d;
  logic [WO-1:0] dat_a, dat_b, dat_c, dat_d;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  // registered: graph 0 positive, graph 1 negated
  shiftadd_cmul #(.W_IN(W), .GRAPH(0), .NEGATE(1'b0), .REG_OUT(1'b1)) u_shiftadd_cmul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a), .in_data(in_data),
    .out_valid(vld_a), .out_ready(out_ready), .out_data(dat_a));
  shiftadd_cmul #(.W_IN(W), .GRAPH(1), .NEGATE(1'b1), .REG_OUT(1'b1)) u_b_neg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b), .in_data(in_data),
    .out_valid(vld_b), .out_ready(out_ready), .out_data(dat_b));
  // combinational: graph 0 negated, graph 1 positive
  shiftadd_cmul #(.W_IN(W), .GRAPH(0), .NEGATE(1'b1), .REG_OUT(1'b0)) u_a_neg_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_c), .in_data(in_data),
    .out_valid(vld_c), .out_ready(out_ready), .out_data(dat_c));
  shiftadd_cmul #(.W_IN(W), .GRAPH(1), .NEGATE(1'b0), .REG_OUT(1'b0)) u_b_pos_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_d), .in_data(in_data),
    .out_valid(vld_d), .out_ready(out_ready), .out_data(dat_d));

  function automatic longint mul(input logic [W-1:0] v, input bit neg);
    longint p;
    p = 64'sd1717 * longint'($signed(v));
    return neg ? -p : p;
  endfunction

  function automatic longint sx(input logic [WO-1:0] d);
    return longint'($signed(d));
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard: pushed on acceptance, popped on output handshake
  logic [W-1:0] q_x[$];
  int           q_c[$];
  bit           stall_q = 1'b0;
  logic [WO-1:0] hold_a, hold_b;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (stall_q) begin
        chk("R7 hold valid", longint'(vld_a & vld_b), 1);
        chk("R7 hold data a", sx(dat_a), sx(hold_a));
        chk("R7 hold data b", sx(dat_b), sx(hold_b));
      end
      if (vld_a && out_ready) begin
        if (q_x.size() == 0) begin
          chk("R6 unexpected output", 1, 0);
        end else begin
          logic [W-1:0] xv;
          int c0;
          xv = q_x.pop_front();
          c0 = q_c.pop_front();
          chk("R1/R3 graph0 +", sx(dat_a), mul(xv, 1'b0));
          chk("R2/R3 graph1 -", sx(dat_b), mul(xv, 1'b1));
          if (!bp_en) chk("R6 latency", longint'(cyc - c0), 1);
        end
      end
      if (vld_a) chk("R7 ready rule", longint'(rdy_a), longint'(out_ready));
      stall_q = vld_a && !out_ready;
      hold_a  = dat_a;
      hold_b  = dat_b;
      if (in_valid && rdy_a) begin
        q_x.push_back(in_data);
        q_c.push_back(cyc);
      end
    end
  end

  // consumer: random back-pressure when enabled
  logic [31:0] rdy_lfsr = 32'h1ACE_B00C;
  always @(posedge clk) begin
    #2;
    rdy_lfsr = {rdy_lfsr[30:0], rdy_lfsr[31] ^ rdy_lfsr[21] ^ rdy_lfsr[1] ^ rdy_lfsr[0]};
    out_ready = !bp_en || rdy_lfsr[3];
  end

  task automatic send(input logic [W-1:0] v);
    bit done;
    in_data  = v;
    in_valid = 1'b1;
    #1;
    chk("R9 comb valid", longint'(vld_c & vld_d), 1);
    chk("R9 comb ready", longint'(rdy_d), longint'(out_ready));
    chk("R2/R3 comb graph0 -", sx(dat_c), mul(v, 1'b1));
    chk("R1/R3 comb graph1 +", sx(dat_d), mul(v, 1'b0));
    chk("R5 parity", longint'(dat_d[0] ^ dat_c[0]), 0);
    chk("R5 parity in", longint'(dat_d[0]), longint'(v[0]));
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      done = rdy_a;
      @(posedge clk);
      #2;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && q_x.size() != 0; i++) @(posedge clk);
    #2;
    chk("R6 drained", longint'(q_x.size()), 0);
  endtask

  logic [31:0] dat_lfsr = 32'hC0DE_5EED;
  function automatic logic [W-1:0] next_val();
    dat_lfsr = dat_lfsr ^ (dat_lfsr << 13);
    dat_lfsr = dat_lfsr ^ (dat_lfsr >> 17);
    dat_lfsr = dat_lfsr ^ (dat_lfsr << 5);
    return dat_lfsr[W-1:0];
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", longint'(vld_a | vld_b), 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 idle after reset", longint'(vld_a | vld_b), 0);
    #1;
    // directed, then extremes (R4)
    send(16'sd0);
    send(16'sd1);
    send(-16'sd1);
    send(16'sd2);
    send(16'sd12345);
    send(16'h7FFF);
    send(16'h8000);
    drain();
    chk("R4 max +", mul(16'h7FFF, 1'b0), 64'sd56260939);
    chk("R4 min -", mul(16'h8000, 1'b1), 64'sd56262656);
    for (int i = 0; i < 40; i++) send(next_val());
    drain();
    bp_en = 1'b1;
    for (int i = 0; i < 80; i++) send(next_val());
    send(16'h8000);
    send(16'h7FFF);
    drain();
    bp_en = 1'b0;
    repeat (3) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule